// File: doc/BRIEF.md
# At-Speed Delay Test Sequencer

This block runs one two-pattern delay test on a scan chain from a single fast clock. It does not gate that clock. Instead it drives a one-cycle clock enable that is shared by every flop in the chain, together with a scan-enable. A test starts with a start pulse. The controller then loads the first vector at a reduced shift rate. Next it issues two enables in back-to-back fast cycles: one to launch the transition and one to capture the result. Last, it unloads the captured response at the reduced rate while the next pattern loads in behind it.

Two launch styles are available. In the functional-launch style, both pulses use the functional data path. In the shift-launch style, the launch pulse is one extra scan shift and only the capture pulse is functional. A small chain of functional flops with a mux-D scan input is built in, so the whole sequence can be observed end to end. Each flop's functional input is the XOR of its own value and the value of the next flop in the ring.

Top module: `delay_test_sequencer`

## Requirements
- R1: After a start pulse accepted in idle, the block performs CHAIN_LEN load shifts. Each shift is a one-cycle flop_ce with scan_en high. The first shift is DIV cycles after the start edge, and the following shifts are DIV cycles apart. scan_en stays high for the whole load.
- R2: scan_in is taken only on cycles with both flop_ce and scan_en high. A shift moves flop i to flop i+1 and puts scan_in into flop 0. scan_out always shows the last flop (index CHAIN_LEN-1), so the first bit shifted in ends up in the last flop.
- R3: With los_mode low at start, the cycle after the last load shift and the cycle after that both carry flop_ce with scan_en low. Each flop then takes q[i] XOR q[(i+1) mod CHAIN_LEN].
- R4: With los_mode high at start, the cycle after the last load shift carries flop_ce with scan_en high. This is one extra shift that takes a scan_in bit. The next cycle carries flop_ce with scan_en low, which is the functional capture. los_mode is sampled only at start.
- R5: After capture, CHAIN_LEN unload shifts follow at the same DIV spacing, the first one DIV cycles after the capture cycle. Before each unload shift, scan_out shows the captured response starting from the last flop. The next pattern enters through scan_in at the same time.
- R6: busy is high from the cycle after the start edge through the done cycle. done is high for exactly one cycle, 2*CHAIN_LEN*DIV+3 cycles after the start edge. After that the block is idle.
- R7: A start pulse that arrives while busy is high has no effect on the sequence or its timing.
- R8: After reset, busy, done, flop_ce and scan_en are low, and every chain flop holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a test |
| los_mode | input | 1 | 1 selects shift launch, 0 selects functional launch |
| scan_in | input | 1 | Serial pattern bit into chain flop 0 |
| flop_ce | output | 1 | Per-cycle clock enable shared by all chain flops |
| scan_en | output | 1 | Selects the scan path at the chain flops |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| scan_out | output | 1 | Last chain flop |

## Verification
The hardest condition to reach from the ports is the hand-off in shift-launch mode. There, the last load shift, the extra launch shift and the capture fall in consecutive cycles, and scan_in must supply a fresh bit exactly at the launch. The driver feeds scan_in one bit per observed shift, so that extra bit lands exactly at launch. The monitor then confirms, through the unloaded response, that the launched vector was the loaded vector moved by one place. Stray start pulses are also injected in the middle of a load and in the launch cycle, while the cycle-exact timing check is running.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT_IN,
    ST_LAUNCH,
    ST_CAPTURE,
    ST_SHIFT_OUT,
    ST_DONE
  } dts_state_t;
endpackage

// File: rtl/dts_rst_sync.sv
module dts_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
  import dts_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int DIV       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic los_mode,
  output logic flop_ce,
  output logic scan_en,
  output logic busy,
  output logic done
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BCW = $clog2(CHAIN_LEN) + 1;
  localparam logic [DCW-1:0] DIV_LAST = DCW'(DIV - 1);
  localparam logic [BCW-1:0] BIT_LAST = BCW'(CHAIN_LEN - 1);

  dts_state_t     state_q, state_d;
  logic [DCW-1:0] div_q, div_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic           los_q, los_d;
  logic           shifting, tick;

  assign shifting = (state_q == ST_SHIFT_IN) || (state_q == ST_SHIFT_OUT);
  assign tick     = shifting && (div_q == DIV_LAST);

  always_comb begin
    state_d = state_q;
    div_d   = div_q;
    bit_d   = bit_q;
    los_d   = los_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SHIFT_IN;
          div_d   = '0;
          bit_d   = '0;
          los_d   = los_mode;
        end
      end
      ST_SHIFT_IN, ST_SHIFT_OUT: begin
        if (tick) begin
          div_d = '0;
          if (bit_q == BIT_LAST) begin
            bit_d   = '0;
            state_d = (state_q == ST_SHIFT_IN) ? ST_LAUNCH : ST_DONE;
          end else begin
            bit_d = bit_q + BCW'(1);
          end
        end else begin
          div_d = div_q + DCW'(1);
        end
      end
      ST_LAUNCH:  state_d = ST_CAPTURE;
      ST_CAPTURE: begin
        state_d = ST_SHIFT_OUT;
        div_d   = '0;
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      los_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      los_q   <= los_d;
    end
  end

  assign flop_ce = tick || (state_q == ST_LAUNCH) || (state_q == ST_CAPTURE);
  assign scan_en = shifting || ((state_q == ST_LAUNCH) && los_q);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);

  // R1: shift enables are isolated single-cycle pulses
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3: capture follows launch in the very next fast cycle, functionally
  assert_capture_follows_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LAUNCH) |=> (flop_ce && !scan_en && state_q == ST_CAPTURE));

  // R4: the launch cycle used the scan path exactly when shift launch was chosen
  assert_launch_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPTURE) |-> ($past(scan_en) == los_q));

  // R6: done is a single pulse and returns the block to idle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R7: a running test is never cut short
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/dts_chain.sv
module dts_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic se,
  input  logic si,
  output logic so
);
  logic [CHAIN_LEN-1:0] q, func_d, next_d;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_func
    assign func_d[i] = q[i] ^ q[(i + 1) % CHAIN_LEN];
  end

  assign next_d = se ? {q[CHAIN_LEN-2:0], si} : func_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= next_d;
  end

  assign so = q[CHAIN_LEN-1];

  // R2: a shift takes scan_in into the head flop
  assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && se) |=> (q[0] == $past(si)));

  // R2: a shift moves the next-to-last bit to the scan output
  assert_shift_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && se) |=> (so == $past(q[CHAIN_LEN-2])));
endmodule

// File: rtl/delay_test_sequencer.sv
module delay_test_sequencer #(
  parameter int CHAIN_LEN = 8,
  parameter int DIV       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic los_mode,
  input  logic scan_in,
  output logic flop_ce,
  output logic scan_en,
  output logic busy,
  output logic done,
  output logic scan_out
);
  logic rst_n_s;

  dts_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dts_fsm #(.CHAIN_LEN(CHAIN_LEN), .DIV(DIV)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (start),
    .los_mode (los_mode),
    .flop_ce  (flop_ce),
    .scan_en  (scan_en),
    .busy     (busy),
    .done     (done)
  );

  dts_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ce    (flop_ce),
    .se    (scan_en),
    .si    (scan_in),
    .so    (scan_out)
  );
endmodule

// File: tb/delay_test_sequencer_test.sv
module delay_test_sequencer_test;
  localparam int L   = 8;
  localparam int D   = 4;
  localparam int TOT = 2 * L * D + 3;

  typedef struct {
    logic  val;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, start, los_mode, scan_in;
  logic flop_ce, scan_en, busy, done, scan_out;
  int   checks = 0;
  int   errors = 0;
  bit   live = 1'b0;
  exp_t exp_q[$];
  logic [L-1:0] chain_now;

  always #4 clk = ~clk;

  delay_test_sequencer #(.CHAIN_LEN(L), .DIV(D)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .los_mode(los_mode),
    .scan_in(scan_in), .flop_ce(flop_ce), .scan_en(scan_en),
    .busy(busy), .done(done), .scan_out(scan_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [L-1:0] func_next(input logic [L-1:0] q);
    logic [L-1:0] r;
    for (int i = 0; i < L; i++) r[i] = q[i] ^ q[(i + 1) % L];
    return r;
  endfunction

  // monitor: every scan shift pops one expected scan_out bit
  always @(negedge clk) begin
    if (live && flop_ce && scan_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2", "unexpected shift", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(scan_out == e.val, e.req, "scan_out", int'(scan_out), int'(e.val));
      end
    end
  end

  // driver: pushes expectations, then runs one test with cycle-exact timing checks
  task automatic run_test(input logic [L-1:0] v1, input logic [L-1:0] nxt,
                          input bit los, input bit lbit, input int poke,
                          input string load_req);
    logic [2*L:0] stream;
    logic [L-1:0] v2, resp;
    int base, idx, done_at;
    bit prev_tick;
    exp_t e;
    stream = '0;
    for (int k = 0; k < L; k++) begin
      stream[k] = v1[L-1-k];
      e.val = chain_now[L-1-k]; e.req = load_req; exp_q.push_back(e);
    end
    if (los) begin
      stream[L] = lbit;
      e.val = v1[L-1]; e.req = "R4"; exp_q.push_back(e);
      v2 = {v1[L-2:0], lbit};
      base = L + 1;
    end else begin
      v2 = func_next(v1);
      base = L;
    end
    resp = func_next(v2);
    for (int k = 0; k < L; k++) begin
      stream[base+k] = nxt[L-1-k];
      e.val = resp[L-1-k]; e.req = los ? "R4" : "R3"; exp_q.push_back(e);
    end
    chain_now = nxt;

    @(negedge clk);
    los_mode = los; scan_in = stream[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0; los_mode = ~los;  // R4: later mode changes are ignored
    idx = 0; prev_tick = 1'b0; done_at = -1;
    for (int n = 1; n <= TOT + 1; n++) begin
      bit e_ce, e_se;
      string tag;
      if (n > 1) @(negedge clk);
      if (prev_tick) idx++;
      scan_in = (idx <= 2 * L) ? stream[idx] : 1'b0;
      start = (n == poke);
      if (n <= L * D) begin
        e_ce = (n % D == 0); e_se = 1'b1; tag = "R1";
      end else if (n == L * D + 1) begin
        e_ce = 1'b1; e_se = los; tag = los ? "R4" : "R3";
      end else if (n == L * D + 2) begin
        e_ce = 1'b1; e_se = 1'b0; tag = los ? "R4" : "R3";
      end else if (n < TOT) begin
        e_ce = ((n - (L * D + 2)) % D == 0); e_se = 1'b1; tag = "R5";
      end else begin
        e_ce = 1'b0; e_se = 1'b0; tag = "R6";
      end
      chk(flop_ce == e_ce, tag, "flop_ce", int'(flop_ce), int'(e_ce));
      chk(scan_en == e_se, tag, "scan_en", int'(scan_en), int'(e_se));
      chk(busy == (n <= TOT), "R6", "busy", int'(busy), int'(n <= TOT));
      chk(done == (n == TOT), "R6", "done", int'(done), int'(n == TOT));
      if (done) done_at = n;
      prev_tick = flop_ce && scan_en;
    end
    start = 1'b0;
    if (poke > 0) chk(done_at == TOT, "R7", "done cycle after stray start", done_at, TOT);
    chk(exp_q.size() == 0, "R5", "leftover expected bits", exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; los_mode = 1'b0; scan_in = 1'b0;
    chain_now = '0;
    repeat (3) @(negedge clk);
    chk({busy, done, flop_ce, scan_en, scan_out} == 5'b0, "R8", "outputs in reset",
        int'({busy, done, flop_ce, scan_en, scan_out}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, done, flop_ce, scan_en, scan_out} == 5'b0, "R8", "outputs after reset",
        int'({busy, done, flop_ce, scan_en, scan_out}), 0);
    live = 1'b1;
    run_test(8'hA5, 8'h3C, 1'b0, 1'b0, 0,      "R8");  // functional launch, chain starts at 0
    run_test(8'h96, 8'h0F, 1'b1, 1'b1, 0,      "R5");  // shift launch, new bit 1
    run_test(8'hFF, 8'h00, 1'b0, 1'b0, 20,     "R5");  // stray start during load
    run_test(8'h01, 8'hC3, 1'b1, 1'b0, L*D+1,  "R5");  // stray start in launch cycle
    run_test(8'h00, 8'h5A, 1'b0, 1'b0, 0,      "R5");  // all-zero vector
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule